// File: doc/BRIEF.md
# Host Address Segment-Line Fold Decoder

This block sits between a 32-bit host address bus and a video controller that has three segment-match inputs and two extra address inputs. It folds the upper host address bits down to three segment lines. It also passes host address bits 23 and 22 straight through. The controller compares these five lines against its own window register. How the upper bits are folded decides which host addresses that register can reach.

A two-bit style input picks one of three folds, and the fourth code is reserved.
- **Invert style** inverts bits 26..24. The window repeats every 128 MB.
- **Pair-NOR style** checks three pairs of address lines for all-zero. This extends decoding up to bit 29.
- **Base-match style** compares the top address byte with a programmable 16 MB region base. The base has its own enable bit.

For I/O cycles the segment lines are held low, so the controller never claims an I/O access. The fold is purely combinational. Only the region base and its enable are clocked.

Top module: `seg_fold_top`

## Requirements
- R1: In invert style (style code 0), for a memory cycle, seg[i] equals the inverse of host address bit 24+i for i = 0..2, and host address bits 31..27 have no effect on any output.
- R2: In pair-NOR style (style code 1), for a memory cycle, seg[i] is 1 only when host address bits 24+2i and 25+2i are both 0, for i = 0..2; bits 31..30 have no effect.
- R3: In base-match style (style code 2), for a memory cycle whose host address bits 31..24 are all zero, seg is 3'b111, whatever the region base and enable hold.
- R4: In base-match style, for a memory cycle with a nonzero top byte, seg is 3'b110 when the enable is set and the top byte equals the stored region base; otherwise seg is 3'b000.
- R5: While the region enable is clear, seg never shows 3'b110 in base-match style.
- R6: For an I/O cycle (is_mem = 0), seg is 3'b000 in every style.
- R7: fwd_a23 and fwd_a22 always equal host address bits 23 and 22, in every style and cycle type.
- R8: A write strobe loads the region base from wr_data[31:24] and the enable from wr_enable on the next rising clock edge. base_rdata returns the base in bits 31..24 with bits 23..0 reading zero. Reset clears both the base and the enable.
- R9: Style code 3 is reserved and drives seg to 3'b000 for every address.
- R10: In invert style, take any byte address B below 128 MB that is a multiple of 4 MB. An access inside the 4 MB window at B gives the five-bit compare code {seg[2:0], fwd_a23, fwd_a22} = (B / 4 MB) XOR 0x1C. For example, B = 68 MB gives 0x0D.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the region base register |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_addr | input | 32 | Host byte address |
| is_mem | input | 1 | 1 for a memory cycle, 0 for an I/O cycle |
| fold_style | input | 2 | 0 invert, 1 pair-NOR, 2 base-match, 3 reserved |
| wr_en | input | 1 | Write strobe for the region base and enable |
| wr_data | input | 32 | Region base write data; bits 31..24 are kept |
| wr_enable | input | 1 | Region enable value loaded on a write |
| seg | output | 3 | Segment-match lines to the controller |
| fwd_a23 | output | 1 | Forwarded host address bit 23 |
| fwd_a22 | output | 1 | Forwarded host address bit 22 |
| base_rdata | output | 32 | Region base readback, low 24 bits zero |
| base_on | output | 1 | Current region enable |

## Verification
The bench builds the block with the defaults: a 32-bit address, three segment lines, and the fold starting at bit 24. With these values every fold is reachable. The inverter mirror shows up at the 128 MB boundary. The pair-NOR reach ends at bit 29, and the 16 MB base byte occupies bits 31..24. A sweep over all 4 MB windows below 128 MB checks the invert-style compare-code rule. Directed writes check the region base against its enable and its all-zero priority.

// File: rtl/seg_fold_pkg.sv
package seg_fold_pkg;

  typedef enum logic [1:0] {
    STYLE_INV  = 2'd0,
    STYLE_NOR  = 2'd1,
    STYLE_BASE = 2'd2,
    STYLE_RSVD = 2'd3
  } fold_style_e;

  localparam logic [2:0] SEG_NONE  = 3'b000;
  localparam logic [2:0] SEG_LOW   = 3'b111;
  localparam logic [2:0] SEG_MATCH = 3'b110;

  // Five-bit compare code the controller sees for a given top slice.
  function automatic logic [4:0] compare_code(input logic [2:0] s, input logic [1:0] fwd);
    return {s, fwd};
  endfunction

  // Pair-NOR of two address lines.
  function automatic logic pair_clear(input logic [1:0] pair);
    return (pair == 2'b00);
  endfunction

endpackage

// File: rtl/seg_inv_fold.sv
module seg_inv_fold #(
  parameter int SEG_W = 3
) (
  input  logic [SEG_W-1:0] addr_slice,
  output logic [SEG_W-1:0] seg_out
);
  for (genvar i = 0; i < SEG_W; i++) begin : g_inv
    assign seg_out[i] = ~addr_slice[i];
  end
endmodule

// File: rtl/seg_nor_fold.sv
module seg_nor_fold #(
  parameter int SEG_W = 3
) (
  input  logic [2*SEG_W-1:0] addr_slice,
  output logic [SEG_W-1:0]   seg_out
);
  import seg_fold_pkg::*;
  for (genvar i = 0; i < SEG_W; i++) begin : g_pair
    assign seg_out[i] = pair_clear(addr_slice[2*i +: 2]);
  end
endmodule

// File: rtl/seg_base_fold.sv
module seg_base_fold #(
  parameter int SEG_W  = 3,
  parameter int BASE_W = 8
) (
  input  logic [BASE_W-1:0] top_byte,
  input  logic [BASE_W-1:0] base_hi,
  input  logic              base_on,
  output logic [SEG_W-1:0]  seg_out,
  output logic              hit_low,
  output logic              hit_base
);
  import seg_fold_pkg::*;
  assign hit_low  = (top_byte == '0);
  assign hit_base = base_on && (top_byte == base_hi) && !hit_low;

  always_comb begin
    if (hit_low)       seg_out = SEG_LOW;
    else if (hit_base) seg_out = SEG_MATCH;
    else               seg_out = SEG_NONE;
  end
endmodule

// File: rtl/seg_base_reg.sv
module seg_base_reg #(
  parameter int ADDR_W = 32,
  parameter int BASE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic              wr_enable,
  output logic [BASE_W-1:0] base_hi,
  output logic              base_on
);
  localparam int LSB = ADDR_W - BASE_W;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_hi <= '0;
      base_on <= 1'b0;
    end else if (wr_en) begin
      base_hi <= wr_data[ADDR_W-1:LSB];
      base_on <= wr_enable;
    end
  end

  wire unused_low = ^wr_data[LSB-1:0];

  // R8: write lands one edge later
  assert_base_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (base_hi == $past(wr_data[ADDR_W-1:LSB])) && (base_on == $past(wr_enable)));
  // R8: no write leaves the register unchanged
  assert_base_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(base_hi) && $stable(base_on));
endmodule

// File: rtl/seg_fold_top.sv
module seg_fold_top #(
  parameter int ADDR_W   = 32,
  parameter int SEG_W    = 3,
  parameter int FOLD_LSB = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              is_mem,
  input  logic [1:0]        fold_style,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic              wr_enable,
  output logic [SEG_W-1:0]  seg,
  output logic              fwd_a23,
  output logic              fwd_a22,
  output logic [ADDR_W-1:0] base_rdata,
  output logic              base_on
);
  import seg_fold_pkg::*;

  localparam int BASE_W = ADDR_W - FOLD_LSB;
  localparam int FWD_HI = FOLD_LSB - 1;
  localparam int FWD_LO = FOLD_LSB - 2;

  fold_style_e style;
  assign style = fold_style_e'(fold_style);

  logic [BASE_W-1:0] base_hi;
  logic [SEG_W-1:0]  seg_inv, seg_nor, seg_base;
  logic              base_hit_low, base_hit_match;
  logic [SEG_W-1:0]  seg_sel;

  seg_base_reg #(.ADDR_W(ADDR_W), .BASE_W(BASE_W)) u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .wr_enable(wr_enable), .base_hi(base_hi), .base_on(base_on)
  );

  seg_inv_fold #(.SEG_W(SEG_W)) u_inv (
    .addr_slice(host_addr[FOLD_LSB +: SEG_W]), .seg_out(seg_inv)
  );

  seg_nor_fold #(.SEG_W(SEG_W)) u_nor (
    .addr_slice(host_addr[FOLD_LSB +: 2*SEG_W]), .seg_out(seg_nor)
  );

  seg_base_fold #(.SEG_W(SEG_W), .BASE_W(BASE_W)) u_base (
    .top_byte(host_addr[ADDR_W-1:FOLD_LSB]), .base_hi(base_hi), .base_on(base_on),
    .seg_out(seg_base), .hit_low(base_hit_low), .hit_base(base_hit_match)
  );

  always_comb begin
    unique case (style)
      STYLE_INV:  seg_sel = seg_inv;
      STYLE_NOR:  seg_sel = seg_nor;
      STYLE_BASE: seg_sel = seg_base;
      default:    seg_sel = '0;
    endcase
  end

  assign seg        = is_mem ? seg_sel : '0;
  assign fwd_a23    = host_addr[FWD_HI];
  assign fwd_a22    = host_addr[FWD_LO];
  assign base_rdata = {base_hi, {FOLD_LSB{1'b0}}};

  wire unused_low = ^host_addr[FWD_LO-1:0];

  // R6: I/O cycles never claim
  assert_io_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !is_mem |-> seg == '0);
  // R1: invert style follows the inverted lines
  assert_inv_follow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (is_mem && fold_style == 2'd0) |-> seg == ~host_addr[FOLD_LSB +: SEG_W]);
  // R2: pair-NOR lowest line
  assert_nor_pair0_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (is_mem && fold_style == 2'd1) |-> seg[0] == (host_addr[FOLD_LSB +: 2] == 2'b00));
  // R3: all-zero top byte wins in base style
  assert_base_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (is_mem && fold_style == 2'd2 && host_addr[ADDR_W-1:FOLD_LSB] == '0) |-> seg == 3'b111);
  // R5: no match while disabled
  assert_no_match_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fold_style == 2'd2 && !base_on) |-> seg != 3'b110);
  // R4: match only from the base comparator
  assert_match_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (seg == 3'b110 && fold_style == 2'd2) |-> base_hit_match);
  // R9: reserved code stays quiet
  assert_rsvd_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fold_style == 2'd3 |-> seg == '0);
endmodule

// File: tb/seg_fold_top_tb.sv
module seg_fold_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] host_addr = '0;
  logic        is_mem = 1'b0;
  logic [1:0]  fold_style = 2'd0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        wr_enable = 1'b0;
  logic [2:0]  seg;
  logic        fwd_a23, fwd_a22, base_on;
  logic [31:0] base_rdata;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  seg_fold_top dut_i (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .is_mem(is_mem),
    .fold_style(fold_style), .wr_en(wr_en), .wr_data(wr_data), .wr_enable(wr_enable),
    .seg(seg), .fwd_a23(fwd_a23), .fwd_a22(fwd_a22),
    .base_rdata(base_rdata), .base_on(base_on)
  );

  // {style[1:0], is_mem, addr[31:0], seg[2:0], a23a22[1:0]}; base = 0x45, enabled
  localparam logic [39:0] VEC [14] = '{
    {2'd0, 1'b1, 32'h000A0000, 3'b111, 2'b00},  // R1 low memory
    {2'd0, 1'b1, 32'h04400000, 3'b011, 2'b01},  // R1/R10 68 MB -> 0x0D
    {2'd0, 1'b1, 32'hF8000000, 3'b111, 2'b00},  // R1 upper bits ignored
    {2'd0, 1'b0, 32'h000A0000, 3'b000, 2'b00},  // R6 io
    {2'd1, 1'b1, 32'h00C00000, 3'b111, 2'b11},  // R2/R7
    {2'd1, 1'b1, 32'h01000000, 3'b110, 2'b00},  // R2 pair0
    {2'd1, 1'b1, 32'h0C000000, 3'b101, 2'b00},  // R2 pair1
    {2'd1, 1'b1, 32'h30000000, 3'b011, 2'b00},  // R2 pair2
    {2'd1, 1'b1, 32'hC0000000, 3'b111, 2'b00},  // R2 bits 31..30 ignored
    {2'd2, 1'b1, 32'h000A0000, 3'b111, 2'b00},  // R3
    {2'd2, 1'b1, 32'h45800000, 3'b110, 2'b10},  // R4 match
    {2'd2, 1'b1, 32'h46000000, 3'b000, 2'b00},  // R4 miss
    {2'd2, 1'b0, 32'h45000000, 3'b000, 2'b00},  // R6 io in base
    {2'd3, 1'b1, 32'h00000000, 3'b000, 2'b00}   // R9 reserved
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic apply(input logic [1:0] st, input logic mem, input logic [31:0] a);
    @(negedge clk);
    fold_style = st; is_mem = mem; host_addr = a;
    #1;
  endtask

  task automatic write_base(input logic [31:0] d, input logic en);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d; wr_enable = en;
    @(negedge clk);
    wr_en = 1'b0;
    #1;
  endtask

  initial begin
    #200000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog got=hang exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R8 reset state
    check("R8 reset base", base_rdata, 32'h0);
    check("R8 reset enable", {31'b0, base_on}, 32'h0);

    // R5 with enable clear, base zero
    apply(2'd2, 1'b1, 32'h45000000);
    check("R5 off miss", {29'b0, seg}, 32'd0);
    apply(2'd2, 1'b1, 32'h00100000);
    check("R3 low w/ off", {29'b0, seg}, 32'd7);

    // R8 write without enable, low bits read zero
    write_base(32'h45123456, 1'b0);
    check("R8 readback", base_rdata, 32'h45000000);
    check("R8 enable kept 0", {31'b0, base_on}, 32'h0);
    apply(2'd2, 1'b1, 32'h45800000);
    check("R5 base set but off", {29'b0, seg}, 32'd0);

    write_base(32'h45FFFFFF, 1'b1);
    check("R8 enable set", {31'b0, base_on}, 32'h1);
    check("R8 readback2", base_rdata, 32'h45000000);

    for (int i = 0; i < 14; i++) begin
      apply(VEC[i][39:38], VEC[i][37], VEC[i][36:5]);
      check($sformatf("R1-R9 vec%0d seg", i), {29'b0, seg}, {29'b0, VEC[i][4:2]});
      check($sformatf("R7 vec%0d fwd", i), {30'b0, fwd_a23, fwd_a22}, {30'b0, VEC[i][1:0]});
    end

    // R10 sweep of invert-style windows below 128 MB
    for (int k = 0; k < 32; k++) begin
      logic [31:0] a;
      logic [4:0]  want;
      a = (32'(k) * 32'h00400000) + 32'h0001F00C;
      want = 5'(k) ^ 5'h1C;
      apply(2'd0, 1'b1, a);
      check($sformatf("R10 win%0d", k), {27'b0, seg, fwd_a23, fwd_a22}, {27'b0, want});
      // R1 mirror: same window one 128 MB step up
      apply(2'd0, 1'b1, a + 32'h08000000);
      check($sformatf("R1 mirror%0d", k), {27'b0, seg, fwd_a23, fwd_a22}, {27'b0, want});
    end

    // R4: zero base enabled -> all-zero case still 111, no 110 anywhere sampled
    write_base(32'h00000000, 1'b1);
    apply(2'd2, 1'b1, 32'h00000000);
    check("R4 zero base low", {29'b0, seg}, 32'd7);
    apply(2'd2, 1'b1, 32'h01000000);
    check("R4 zero base miss", {29'b0, seg}, 32'd0);

    // R4 top base byte
    write_base(32'hFF000000, 1'b1);
    apply(2'd2, 1'b1, 32'hFFC00000);
    check("R4 top byte match", {29'b0, seg}, 32'd6);
    apply(2'd2, 1'b0, 32'hFFC00000);
    check("R6 io top match", {29'b0, seg}, 32'd0);

    // R9 reserved with matching address
    apply(2'd3, 1'b1, 32'hFF000000);
    check("R9 reserved", {29'b0, seg}, 32'd0);

    // R8 reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R8 async clear base", base_rdata, 32'h0);
    check("R8 async clear en", {31'b0, base_on}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule